// File: doc/BRIEF.md
# Multi-core interrupt priority arbiter

This block holds the enable, pending, priority and routing state for a set of interrupt sources shared by several CPU ports, and for every CPU names the single interrupt that should be presented to it next. Each CPU sees its result in three forms: the winning interrupt ID, that interrupt's priority value, and an interrupt-request line.

The ID space starts with 32 internal IDs that are private to each CPU, with a separate copy of their state for every CPU. Shared IDs follow, and a target mask decides which CPUs may receive each of them. Software reaches the state through a single-cycle write port that carries an operation code, a CPU select, an address and a data word. Active status comes in on a separate input vector, one bit per CPU and ID. Selection is combinational on the stored state, so a write changes the outputs from the clock edge that accepts it. A change on the active input changes them in the same cycle.

Top module: `arb_top`

## Requirements
- R1: After reset every enable, pending bit, priority, target mask and per-CPU priority mask is 0 and the distributor enable is off. Every CPU then reports ID 1023 and priority 0xFF, and its request line is low.
- R2: Operation 0 (set-enable) and operation 1 (clear-enable) act on a 32-ID word. The word is selected by the address: word 0 is the writing CPU's internal bank, and word k≥1 holds shared IDs 32k..32k+31. Only data bits that are 1 act, and a 0 bit leaves its enable unchanged.
- R3: Operation 2 (set-pending) and operation 3 (clear-pending) use the same word addressing and the same rule that only 1 bits act.
- R4: An ID is a candidate for a CPU only when it is enabled, pending and not active for that CPU. Active bit c*NUM_IRQ+id belongs to CPU c.
- R5: IDs 0..31 are banked per CPU. Operations on them, including operation 4 (set priority, data[7:0], address = ID), touch only the bank of the CPU named by the CPU select. Each CPU's bank is a candidate only for that CPU.
- R6: A shared ID is a candidate only for the CPUs whose bits are set in its target mask. Operation 5 writes the mask from data[NUM_CPU-1:0], with address = ID, and bit c stands for CPU c.
- R7: The winner is the candidate with the smallest priority value. On a tie the lowest ID wins, and the winner's priority appears on the priority output.
- R8: When a CPU has no candidate, or the distributor enable is off, that CPU reports ID 1023, priority 0xFF and a low request line. Operation 7 writes the distributor enable from data[0].
- R9: A CPU's request line is high only when its winner's priority is strictly less than its priority mask. Operation 6 writes that mask from data[7:0] for the selected CPU.
- R10: A write changes the outputs from the rising edge that accepts it and not before. A change on the active input changes them combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write command valid this cycle |
| wr_op | input | 3 | Operation code (see R2, R3, R5, R6, R8, R9) |
| wr_cpu | input | CPU_W | CPU select for internal-bank and priority-mask operations |
| wr_addr | input | 10 | Word index for bulk operations, ID for per-ID operations |
| wr_data | input | 32 | Write data |
| active_i | input | NUM_CPU*NUM_IRQ | Active flags, bit c*NUM_IRQ+id for CPU c |
| irq_o | output | NUM_CPU | Interrupt request per CPU |
| pend_id_o | output | NUM_CPU*10 | Winning ID per CPU, 1023 when none |
| pend_prio_o | output | NUM_CPU*8 | Winning priority per CPU, 0xFF when none |

## Verification
Corrupted internal state reaches the ports within one cycle, because the selection logic has no registers of its own. A lost or stray enable, pending or target bit shows up at the next sample as a wrong winning ID for some CPU. An enable or pending write that leaks into another CPU's bank does the same. A wrong priority or mask shows as a changed tie winner or a request line that flips at the strict-compare boundary. The bench therefore probes each piece of state right after the edge that wrote it, and probes each other CPU to catch leaks between banks.

// File: rtl/arb_pkg.sv
package arb_pkg;

  localparam int ID_W         = 10;
  localparam int PRIO_W       = 8;
  localparam int INTERNAL_IDS = 32;
  localparam int IDLE_ID      = 1023;

  typedef enum logic [2:0] {
    OP_SET_EN    = 3'd0,
    OP_CLR_EN    = 3'd1,
    OP_SET_PEND  = 3'd2,
    OP_CLR_PEND  = 3'd3,
    OP_SET_PRIO  = 3'd4,
    OP_SET_TGT   = 3'd5,
    OP_SET_PMASK = 3'd6,
    OP_SET_CTRL  = 3'd7
  } arb_op_e;

  // Lower value is more urgent; strict compare keeps the earlier (lower) ID on ties.
  function automatic logic prio_beats(input logic [PRIO_W-1:0] cand_p,
                                      input logic [PRIO_W-1:0] best_p);
    return cand_p < best_p;
  endfunction

  // Request is allowed only strictly below the CPU's mask.
  function automatic logic prio_passes_mask(input logic [PRIO_W-1:0] p,
                                            input logic [PRIO_W-1:0] mask);
    return p < mask;
  endfunction

endpackage

// File: rtl/arb_state.sv
module arb_state
  import arb_pkg::*;
#(
  parameter int NUM_CPU    = 2,
  parameter int NUM_SHARED = 32,
  localparam int NUM_IRQ   = INTERNAL_IDS + NUM_SHARED,
  localparam int CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          wr_valid,
  input  logic [2:0]                                    wr_op,
  input  logic [CPU_W-1:0]                              wr_cpu,
  input  logic [ID_W-1:0]                               wr_addr,
  input  logic [31:0]                                   wr_data,
  output logic [NUM_CPU-1:0][NUM_IRQ-1:0]               en_view,
  output logic [NUM_CPU-1:0][NUM_IRQ-1:0]               pend_view,
  output logic [NUM_CPU-1:0][NUM_IRQ-1:0]               route_view,
  output logic [NUM_CPU-1:0][NUM_IRQ-1:0][PRIO_W-1:0]   prio_view,
  output logic [NUM_CPU-1:0][PRIO_W-1:0]                pmask_q,
  output logic                                          dist_en_q
);

  logic [NUM_CPU-1:0][INTERNAL_IDS-1:0]             int_en_q;
  logic [NUM_CPU-1:0][INTERNAL_IDS-1:0]             int_pend_q;
  logic [NUM_CPU-1:0][INTERNAL_IDS-1:0][PRIO_W-1:0] int_prio_q;
  logic [NUM_SHARED-1:0]                            sh_en_q;
  logic [NUM_SHARED-1:0]                            sh_pend_q;
  logic [NUM_SHARED-1:0][PRIO_W-1:0]                sh_prio_q;
  logic [NUM_SHARED-1:0][NUM_CPU-1:0]               sh_tgt_q;

  // Decoded write targets, named for visibility.
  logic                       cpu_ok;
  logic [INTERNAL_IDS-1:0]    int_bit_hit;
  logic [NUM_SHARED-1:0]      sh_bit_hit;
  logic                       int_id_hit;
  logic [NUM_SHARED-1:0]      sh_id_hit;

  always_comb begin
    cpu_ok      = int'(wr_cpu) < NUM_CPU;
    int_bit_hit = (wr_valid && cpu_ok && wr_addr == '0) ? wr_data : '0;
    int_id_hit  = wr_valid && cpu_ok && (int'(wr_addr) < INTERNAL_IDS);
    for (int s = 0; s < NUM_SHARED; s++) begin
      sh_bit_hit[s] = wr_valid && (wr_addr == ID_W'(s / 32 + 1)) && wr_data[s % 32];
      sh_id_hit[s]  = wr_valid && (wr_addr == ID_W'(INTERNAL_IDS + s));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_en_q   <= '0;
      int_pend_q <= '0;
      int_prio_q <= '0;
      sh_en_q    <= '0;
      sh_pend_q  <= '0;
      sh_prio_q  <= '0;
      sh_tgt_q   <= '0;
      pmask_q    <= '0;
      dist_en_q  <= 1'b0;
    end else if (wr_valid) begin
      case (arb_op_e'(wr_op))
        OP_SET_EN: begin
          for (int b = 0; b < INTERNAL_IDS; b++)
            if (int_bit_hit[b]) int_en_q[wr_cpu][b] <= 1'b1;
          for (int s = 0; s < NUM_SHARED; s++)
            if (sh_bit_hit[s]) sh_en_q[s] <= 1'b1;
        end
        OP_CLR_EN: begin
          for (int b = 0; b < INTERNAL_IDS; b++)
            if (int_bit_hit[b]) int_en_q[wr_cpu][b] <= 1'b0;
          for (int s = 0; s < NUM_SHARED; s++)
            if (sh_bit_hit[s]) sh_en_q[s] <= 1'b0;
        end
        OP_SET_PEND: begin
          for (int b = 0; b < INTERNAL_IDS; b++)
            if (int_bit_hit[b]) int_pend_q[wr_cpu][b] <= 1'b1;
          for (int s = 0; s < NUM_SHARED; s++)
            if (sh_bit_hit[s]) sh_pend_q[s] <= 1'b1;
        end
        OP_CLR_PEND: begin
          for (int b = 0; b < INTERNAL_IDS; b++)
            if (int_bit_hit[b]) int_pend_q[wr_cpu][b] <= 1'b0;
          for (int s = 0; s < NUM_SHARED; s++)
            if (sh_bit_hit[s]) sh_pend_q[s] <= 1'b0;
        end
        OP_SET_PRIO: begin
          if (int_id_hit) int_prio_q[wr_cpu][wr_addr[4:0]] <= wr_data[PRIO_W-1:0];
          for (int s = 0; s < NUM_SHARED; s++)
            if (sh_id_hit[s]) sh_prio_q[s] <= wr_data[PRIO_W-1:0];
        end
        OP_SET_TGT: begin
          for (int s = 0; s < NUM_SHARED; s++)
            if (sh_id_hit[s]) sh_tgt_q[s] <= wr_data[NUM_CPU-1:0];
        end
        OP_SET_PMASK: begin
          if (cpu_ok) pmask_q[wr_cpu] <= wr_data[PRIO_W-1:0];
        end
        OP_SET_CTRL: dist_en_q <= wr_data[0];
        default: ;
      endcase
    end
  end

  // Per-CPU flat view of the ID space.
  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      for (int i = 0; i < INTERNAL_IDS; i++) begin
        en_view[c][i]    = int_en_q[c][i];
        pend_view[c][i]  = int_pend_q[c][i];
        route_view[c][i] = 1'b1;
        prio_view[c][i]  = int_prio_q[c][i];
      end
      for (int s = 0; s < NUM_SHARED; s++) begin
        en_view[c][INTERNAL_IDS+s]    = sh_en_q[s];
        pend_view[c][INTERNAL_IDS+s]  = sh_pend_q[s];
        route_view[c][INTERNAL_IDS+s] = sh_tgt_q[s][c];
        prio_view[c][INTERNAL_IDS+s]  = sh_prio_q[s];
      end
    end
  end

endmodule

// File: rtl/arb_pick.sv
module arb_pick
  import arb_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic [NUM_IRQ-1:0]              cand,
  input  logic [NUM_IRQ-1:0][PRIO_W-1:0]  prio,
  input  logic                            dist_en,
  input  logic [PRIO_W-1:0]               pmask,
  output logic [ID_W-1:0]                 win_id,
  output logic [PRIO_W-1:0]               win_prio,
  output logic                            req
);

  logic              best_valid;
  logic [ID_W-1:0]   best_id;
  logic [PRIO_W-1:0] best_prio;
  logic              found;

  // Ascending scan: a later ID replaces the best only when strictly more urgent.
  always_comb begin
    best_valid = 1'b0;
    best_id    = '0;
    best_prio  = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (cand[i] && (!best_valid || prio_beats(prio[i], best_prio))) begin
        best_valid = 1'b1;
        best_id    = ID_W'(i);
        best_prio  = prio[i];
      end
    end
  end

  assign found    = dist_en && best_valid;
  assign win_id   = found ? best_id : ID_W'(IDLE_ID);
  assign win_prio = found ? best_prio : {PRIO_W{1'b1}};
  assign req      = found && prio_passes_mask(best_prio, pmask);

endmodule

// File: rtl/arb_top.sv
module arb_top
  import arb_pkg::*;
#(
  parameter int NUM_CPU    = 2,
  parameter int NUM_SHARED = 32,
  localparam int NUM_IRQ   = INTERNAL_IDS + NUM_SHARED,
  localparam int CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_valid,
  input  logic [2:0]                  wr_op,
  input  logic [CPU_W-1:0]            wr_cpu,
  input  logic [ID_W-1:0]             wr_addr,
  input  logic [31:0]                 wr_data,
  input  logic [NUM_CPU*NUM_IRQ-1:0]  active_i,
  output logic [NUM_CPU-1:0]          irq_o,
  output logic [NUM_CPU*ID_W-1:0]     pend_id_o,
  output logic [NUM_CPU*PRIO_W-1:0]   pend_prio_o
);

  logic [NUM_CPU-1:0][NUM_IRQ-1:0]              en_view;
  logic [NUM_CPU-1:0][NUM_IRQ-1:0]              pend_view;
  logic [NUM_CPU-1:0][NUM_IRQ-1:0]              route_view;
  logic [NUM_CPU-1:0][NUM_IRQ-1:0][PRIO_W-1:0]  prio_view;
  logic [NUM_CPU-1:0][PRIO_W-1:0]               pmask_q;
  logic                                         dist_en_q;
  logic [NUM_CPU-1:0][NUM_IRQ-1:0]              cand_vec;

  arb_state #(.NUM_CPU(NUM_CPU), .NUM_SHARED(NUM_SHARED)) i_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_op      (wr_op),
    .wr_cpu     (wr_cpu),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .en_view    (en_view),
    .pend_view  (pend_view),
    .route_view (route_view),
    .prio_view  (prio_view),
    .pmask_q    (pmask_q),
    .dist_en_q  (dist_en_q)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    assign cand_vec[c] = en_view[c] & pend_view[c] & route_view[c]
                       & ~active_i[c*NUM_IRQ +: NUM_IRQ];

    arb_pick #(.NUM_IRQ(NUM_IRQ)) i_pick (
      .cand     (cand_vec[c]),
      .prio     (prio_view[c]),
      .dist_en  (dist_en_q),
      .pmask    (pmask_q[c]),
      .win_id   (pend_id_o[c*ID_W +: ID_W]),
      .win_prio (pend_prio_o[c*PRIO_W +: PRIO_W]),
      .req      (irq_o[c])
    );
  end

endmodule

// File: rtl/arb_chk.sv
module arb_chk
  import arb_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_IRQ = 64
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [NUM_CPU*NUM_IRQ-1:0]        active_i,
  input logic [NUM_CPU-1:0]                irq_o,
  input logic [NUM_CPU*ID_W-1:0]           pend_id_o,
  input logic [NUM_CPU*PRIO_W-1:0]         pend_prio_o,
  input logic [NUM_CPU-1:0][NUM_IRQ-1:0]   cand_vec,
  input logic [NUM_CPU-1:0][PRIO_W-1:0]    pmask_q,
  input logic                              dist_en_q
);

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_o == '0));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    logic [ID_W-1:0]   id_c;
    logic [PRIO_W-1:0] pr_c;
    assign id_c = pend_id_o[c*ID_W +: ID_W];
    assign pr_c = pend_prio_o[c*PRIO_W +: PRIO_W];

    a_r9_req_below_mask: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[c] |-> (pr_c < pmask_q[c]));

    a_r8_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      (id_c == ID_W'(IDLE_ID)) |-> (!irq_o[c] && pr_c == '1));

    a_r8_dist_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !dist_en_q |-> (id_c == ID_W'(IDLE_ID)));

    a_r4_winner_not_active: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(id_c) < NUM_IRQ) |-> !active_i[c*NUM_IRQ + int'(id_c)]);

    a_r7_winner_is_candidate: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(id_c) < NUM_IRQ) |-> cand_vec[c][id_c]);
  end

endmodule

bind arb_top arb_chk #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .active_i    (active_i),
  .irq_o       (irq_o),
  .pend_id_o   (pend_id_o),
  .pend_prio_o (pend_prio_o),
  .cand_vec    (cand_vec),
  .pmask_q     (pmask_q),
  .dist_en_q   (dist_en_q)
);

// File: tb/test_arb_top.sv
module test_arb_top;

  localparam int NCPU = 2;
  localparam int NIRQ = 64;

  typedef struct packed {
    logic [2:0]  op;
    logic        cpu;
    logic [9:0]  addr;
    logic [31:0] data;
    logic        chk_cpu;
    logic [9:0]  exp_id;
    logic        exp_irq;
  } vec_t;

  // Each row: one write, then one CPU's id and request line checked after the edge.
  localparam vec_t VECS [24] = '{
    '{3'd7, 1'b0, 10'd0,  32'h1,    1'b0, 10'd1023, 1'b0}, // R8 enable, nothing pending
    '{3'd4, 1'b0, 10'd40, 32'h20,   1'b0, 10'd1023, 1'b0}, // R7 prio only
    '{3'd5, 1'b0, 10'd40, 32'h1,    1'b0, 10'd1023, 1'b0}, // R6 target only
    '{3'd0, 1'b0, 10'd1,  32'h100,  1'b0, 10'd1023, 1'b0}, // R4 enabled, not pending
    '{3'd2, 1'b0, 10'd1,  32'h100,  1'b0, 10'd40,   1'b0}, // R9 mask 0 blocks
    '{3'd6, 1'b0, 10'd0,  32'h21,   1'b0, 10'd40,   1'b1}, // R9 0x20 < 0x21
    '{3'd6, 1'b0, 10'd0,  32'h20,   1'b0, 10'd40,   1'b0}, // R9 equal blocks
    '{3'd6, 1'b0, 10'd0,  32'hFF,   1'b0, 10'd40,   1'b1}, // R9
    '{3'd4, 1'b0, 10'd45, 32'h20,   1'b0, 10'd40,   1'b1}, // R7
    '{3'd5, 1'b0, 10'd45, 32'h1,    1'b0, 10'd40,   1'b1}, // R6
    '{3'd0, 1'b0, 10'd1,  32'h2000, 1'b0, 10'd40,   1'b1}, // R2
    '{3'd2, 1'b0, 10'd1,  32'h2000, 1'b0, 10'd40,   1'b1}, // R7 tie -> lower id
    '{3'd4, 1'b0, 10'd45, 32'h10,   1'b0, 10'd45,   1'b1}, // R7 more urgent
    '{3'd5, 1'b0, 10'd45, 32'h2,    1'b0, 10'd40,   1'b1}, // R6 retarget away
    '{3'd6, 1'b1, 10'd0,  32'hFF,   1'b1, 10'd45,   1'b1}, // R6 seen by cpu1
    '{3'd1, 1'b0, 10'd1,  32'h0,    1'b1, 10'd45,   1'b1}, // R2 zero bits inert
    '{3'd1, 1'b0, 10'd1,  32'h2000, 1'b1, 10'd1023, 1'b0}, // R2 clear enable
    '{3'd4, 1'b1, 10'd3,  32'h5,    1'b0, 10'd40,   1'b1}, // R5 bank prio
    '{3'd0, 1'b1, 10'd0,  32'h8,    1'b1, 10'd1023, 1'b0}, // R4 not pending
    '{3'd2, 1'b1, 10'd0,  32'h8,    1'b1, 10'd3,    1'b1}, // R5 own internal
    '{3'd2, 1'b1, 10'd0,  32'h0,    1'b0, 10'd40,   1'b1}, // R5 R3 no leak, zero inert
    '{3'd3, 1'b0, 10'd1,  32'h100,  1'b0, 10'd1023, 1'b0}, // R3 clear pending
    '{3'd7, 1'b0, 10'd0,  32'h0,    1'b1, 10'd1023, 1'b0}, // R8 distributor off
    '{3'd7, 1'b0, 10'd0,  32'h1,    1'b1, 10'd3,    1'b1}  // R8 back on
  };

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  wr_valid = 1'b0;
  logic [2:0]            wr_op = '0;
  logic [0:0]            wr_cpu = '0;
  logic [9:0]            wr_addr = '0;
  logic [31:0]           wr_data = '0;
  logic [NCPU*NIRQ-1:0]  active_i = '0;
  logic [NCPU-1:0]       irq_o;
  logic [NCPU*10-1:0]    pend_id_o;
  logic [NCPU*8-1:0]     pend_prio_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  arb_top #(.NUM_CPU(NCPU), .NUM_SHARED(32)) i_arb_top (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_op(wr_op),
    .wr_cpu(wr_cpu), .wr_addr(wr_addr), .wr_data(wr_data),
    .active_i(active_i), .irq_o(irq_o), .pend_id_o(pend_id_o),
    .pend_prio_o(pend_prio_o)
  );

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  function automatic int id_of(input int c);
    return int'(pend_id_o[c*10 +: 10]);
  endfunction

  function automatic int prio_of(input int c);
    return int'(pend_prio_o[c*8 +: 8]);
  endfunction

  task automatic write(input logic [2:0] op, input logic cpu,
                       input logic [9:0] addr, input logic [31:0] data);
    @(negedge clk);
    wr_valid = 1'b1; wr_op = op; wr_cpu = cpu; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int c = 0; c < NCPU; c++) begin
      check("R1 reset id", id_of(c), 1023);
      check("R1 reset prio", prio_of(c), 255);
      check("R1 reset irq", int'(irq_o[c]), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", int'(irq_o), 0);

    for (int v = 0; v < 24; v++) begin
      write(VECS[v].op, VECS[v].cpu, VECS[v].addr, VECS[v].data);
      check($sformatf("R2-table row %0d id", v), id_of(int'(VECS[v].chk_cpu)),
            int'(VECS[v].exp_id));
      check($sformatf("R9 table row %0d irq", v), int'(irq_o[VECS[v].chk_cpu]),
            int'(VECS[v].exp_irq));
    end

    // R7 winner priority reported
    check("R7 cpu1 prio", prio_of(1), 5);
    check("R7 cpu0 idle prio", prio_of(0), 255);

    // R4 R10 active input masks the winner in the same cycle
    active_i[NIRQ + 3] = 1'b1;
    #1;
    check("R4 active hides id", id_of(1), 1023);
    check("R10 active immediate irq", int'(irq_o[1]), 0);
    active_i[NIRQ + 3] = 1'b0;
    #1;
    check("R4 inactive restores", id_of(1), 3);
    // R5 another CPU's active bit does not matter
    active_i[3] = 1'b1;
    #1;
    check("R5 other bank active", id_of(1), 3);
    active_i[3] = 1'b0;

    // R10 write takes effect at the accepting edge, not before
    @(negedge clk);
    wr_valid = 1'b1; wr_op = 3'd6; wr_cpu = 1'b1; wr_addr = '0; wr_data = 32'h5;
    #3;
    check("R10 before edge", int'(irq_o[1]), 1);
    @(negedge clk);
    wr_valid = 1'b0;
    check("R10 R9 after edge equal mask", int'(irq_o[1]), 0);
    check("R9 id kept", id_of(1), 3);

    // R1 reset mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    for (int c = 0; c < NCPU; c++) begin
      check("R1 mid reset id", id_of(c), 1023);
      check("R1 mid reset irq", int'(irq_o[c]), 0);
    end
    rst_n = 1'b1;
    write(3'd7, 1'b0, 10'd0, 32'h1);
    check("R1 state cleared", id_of(1), 1023);

    finish_run();
  end

endmodule